// File: doc/BRIEF.md
# Split-Bus Address Arbiter

This block decides which requester owns the address half of a processor bus whose address and data phases run independently. Three off-chip masters and four on-chip masters raise requests, and the block grants the address bus to one of them at a time. Each requester has a 3-bit priority setting. An on-chip requester also presents a level with its request, and that level can lift its priority for that request.

A grant is registered, so it appears on the clock after the decision. When an address tenure is running, the decision waits for that tenure's address acknowledge. The next grant then appears exactly one clock after the acknowledge. When the bus is idle, a grant appears one clock after the request.

A counter tracks data tenures that have been acknowledged but not yet finished. A configuration input limits how many data tenures may be outstanding before a new address tenure is allowed. This lets the bus run without pipelining or with one level of it.

Top module: `addr_arb`

## Requirements
- R1: At most one grant output, across all seven grant bits, is high in any cycle.
- R2: Requesters are numbered 0 to 2 for `ext_req` bits 0 to 2 and 3 to 6 for `int_req` bits 0 to 3. Requester i takes its priority from `prio_cfg[3*i+2:3*i]`, and 7 is the highest value. The grant goes to the pending request with the highest effective priority.
- R3: When pending requests share the highest effective priority, the one with the lowest requester number wins.
- R4: The effective priority of on-chip requester j is the larger of its `prio_cfg` field and its request level `int_lvl[3*j+2:3*j]`. For off-chip requesters, the `prio_cfg` field is used as is.
- R5: While an address tenure is in progress, a new grant can only appear in the cycle right after the cycle in which `addr_ack` is high.
- R6: When the bus is idle and the outstanding-data count permits it, a request is granted on the next clock.
- R7: A grant stays high, on the same requester, until `xfer_start` is seen high. It drops in the following cycle, even if other requests change in the meantime.
- R8: The outstanding-data count rises on each `addr_ack` and falls on each `data_done`. With `pipe_one` = 0, no grant is issued while the count after the current cycle would be nonzero. The withheld grant is issued on the clock at which `data_done` brings the count back to zero.
- R9: With `pipe_one` = 1, a grant may follow an acknowledge while one data tenure is outstanding. A grant is withheld while two are outstanding and is issued once `data_done` lowers the count to one.
- R10: Reset clears all grants and the outstanding-data count. After reset, with `pipe_one` = 0, a fresh request is granted on the next clock.
- R11: Between the transfer start and the address acknowledge of a tenure, no grant is asserted, even when other requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 3 | Off-chip master requests (requesters 0..2) |
| ext_gnt | output | 3 | Off-chip master grants |
| int_req | input | 4 | On-chip master requests (requesters 3..6) |
| int_lvl | input | 12 | Request level of each on-chip master, 3 bits each |
| int_gnt | output | 4 | On-chip master grants |
| prio_cfg | input | 21 | Priority setting of each requester, 3 bits each |
| pipe_one | input | 1 | 1 allows one level of address pipelining, 0 none |
| xfer_start | input | 1 | Transfer start from the granted master |
| addr_ack | input | 1 | Address acknowledge ending the current address tenure |
| data_done | input | 1 | Pulse marking completion of one data tenure |

## Verification
The selection logic is tried with a single request, with distinct priorities, with ties among off-chip masters and among on-chip masters, with an on-chip level that outranks its setting, and with one that does not. Together these separate a winner chosen by priority from one chosen by index, and show whether the request level is applied at all.

The timing tests hold a grant through idle cycles and keep requests pending during an address tenure. They issue acknowledges with zero and with one level of pipelining, so that a grant that is early, late or misplaced by the count shows up as a wrong value on the grant pins in a specific cycle. A reset in the middle of a run, with a data tenure still counted, shows whether the counter is really cleared.

// File: rtl/addr_arb_pkg.sv
package addr_arb_pkg;

    // Width of the stored owner index; covers up to 16 requesters.
    localparam int unsigned OWNER_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no grant, no address tenure
        ST_GRANT = 2'd1,   // grant out, waiting for transfer start
        ST_ADDR  = 2'd2    // address tenure running, waiting for acknowledge
    } arb_state_e;

    typedef struct packed {
        arb_state_e           st;
        logic [OWNER_W-1:0]   owner;
    } arb_reg_t;

endpackage

// File: rtl/addr_arb_eff_prio.sv
module addr_arb_eff_prio #(
    parameter int unsigned N_EXT  = 3,
    parameter int unsigned N_INT  = 4,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned N_REQ = N_EXT + N_INT
) (
    input  logic [N_EXT-1:0]        ext_req,
    input  logic [N_INT-1:0]        int_req,
    input  logic [N_INT*PRIO_W-1:0] int_lvl,
    input  logic [N_REQ*PRIO_W-1:0] prio_cfg,
    output logic [N_REQ-1:0]        req_all,
    output logic [N_REQ*PRIO_W-1:0] prio_all
);

    assign req_all = {int_req, ext_req};

    // Off-chip requesters use their setting directly.
    for (genvar e = 0; e < N_EXT; e++) begin : g_ext
        assign prio_all[e*PRIO_W +: PRIO_W] = prio_cfg[e*PRIO_W +: PRIO_W];
    end

    // On-chip requesters are lifted by the level they present.
    for (genvar j = 0; j < N_INT; j++) begin : g_int
        localparam int unsigned SLOT = N_EXT + j;
        logic [PRIO_W-1:0] cfg_v;
        logic [PRIO_W-1:0] lvl_v;
        assign cfg_v = prio_cfg[SLOT*PRIO_W +: PRIO_W];
        assign lvl_v = int_lvl[j*PRIO_W +: PRIO_W];
        assign prio_all[SLOT*PRIO_W +: PRIO_W] = (lvl_v > cfg_v) ? lvl_v : cfg_v;
    end

endmodule

// File: rtl/addr_arb_pick.sv
module addr_arb_pick #(
    parameter int unsigned N_REQ  = 7,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [N_REQ-1:0]        req,
    input  logic [N_REQ*PRIO_W-1:0] prio,
    output logic                    win_vld,
    output logic [IDX_W-1:0]        win_idx
);

    logic [PRIO_W-1:0] best;

    // Strict comparison keeps the earlier (lower) index on ties.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        best    = '0;
        for (int i = 0; i < int'(N_REQ); i++) begin
            if (req[i] && (!win_vld || (prio[i*PRIO_W +: PRIO_W] > best))) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(i);
                best    = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/addr_arb_tenure_cnt.sv
module addr_arb_tenure_cnt #(
    parameter int unsigned CNT_W = 2,
    parameter int unsigned CAP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && (cnt_q != CAP_V)) begin
            cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/addr_arb.sv
module addr_arb
    import addr_arb_pkg::*;
#(
    parameter int unsigned N_EXT  = 3,
    parameter int unsigned N_INT  = 4,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned N_REQ = N_EXT + N_INT,
    localparam int unsigned CNT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EXT-1:0]        ext_req,
    output logic [N_EXT-1:0]        ext_gnt,
    input  logic [N_INT-1:0]        int_req,
    input  logic [N_INT*PRIO_W-1:0] int_lvl,
    output logic [N_INT-1:0]        int_gnt,
    input  logic [N_REQ*PRIO_W-1:0] prio_cfg,
    input  logic                    pipe_one,
    input  logic                    xfer_start,
    input  logic                    addr_ack,
    input  logic                    data_done
);

    logic [N_REQ-1:0]        req_all;
    logic [N_REQ*PRIO_W-1:0] prio_all;
    logic                    win_vld;
    logic [OWNER_W-1:0]      win_idx;
    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        cnt_d;
    logic                    room;
    logic [N_REQ-1:0]        gnt_all;
    arb_reg_t                cur_q;
    arb_reg_t                nxt_d;

    addr_arb_eff_prio #(
        .N_EXT  (N_EXT),
        .N_INT  (N_INT),
        .PRIO_W (PRIO_W)
    ) u_eff (
        .ext_req  (ext_req),
        .int_req  (int_req),
        .int_lvl  (int_lvl),
        .prio_cfg (prio_cfg),
        .req_all  (req_all),
        .prio_all (prio_all)
    );

    addr_arb_pick #(
        .N_REQ  (N_REQ),
        .PRIO_W (PRIO_W),
        .IDX_W  (OWNER_W)
    ) u_pick (
        .req     (req_all),
        .prio    (prio_all),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    addr_arb_tenure_cnt #(
        .CNT_W (CNT_W),
        .CAP   (2)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (addr_ack),
        .dec   (data_done),
        .cnt_q (cnt_q),
        .cnt_d (cnt_d)
    );

    // A new tenure fits when the count after this cycle stays within depth.
    assign room = (cnt_d <= CNT_W'(pipe_one));

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (win_vld && room) begin
                    nxt_d.st    = ST_GRANT;
                    nxt_d.owner = win_idx;
                end
            end
            ST_GRANT: begin
                if (xfer_start) begin
                    nxt_d.st = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (addr_ack) begin
                    if (win_vld && room) begin
                        nxt_d.st    = ST_GRANT;
                        nxt_d.owner = win_idx;
                    end else begin
                        nxt_d.st = ST_IDLE;
                    end
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, owner: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar g = 0; g < N_REQ; g++) begin : g_gnt
        assign gnt_all[g] = (cur_q.st == ST_GRANT) && (cur_q.owner == OWNER_W'(g));
    end

    assign ext_gnt = gnt_all[N_EXT-1:0];
    assign int_gnt = gnt_all[N_REQ-1:N_EXT];

endmodule

// File: rtl/addr_arb_chk.sv
module addr_arb_chk #(
    parameter int unsigned N_REQ = 7,
    parameter int unsigned CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] gnt,
    input logic             xfer_start,
    input logic             pipe_one,
    input logic [CNT_W-1:0] cnt
);

    a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !xfer_start) |=> (gnt == $past(gnt)));

    a_r7_grant_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && xfer_start) |=> (gnt == '0));

    a_r8_room_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt) |-> (cnt <= CNT_W'(pipe_one)));

    a_r9_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(2));

endmodule

bind addr_arb addr_arb_chk #(
    .N_REQ (N_REQ),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt        (gnt_all),
    .xfer_start (xfer_start),
    .pipe_one   (pipe_one),
    .cnt        (cnt_q)
);

// File: tb/addr_arb_tb.sv
module addr_arb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_req = '0;
    logic [2:0]  ext_gnt;
    logic [3:0]  int_req = '0;
    logic [11:0] int_lvl = '0;
    logic [3:0]  int_gnt;
    logic [20:0] prio_cfg = '0;
    logic        pipe_one = 1'b0;
    logic        xfer_start = 1'b0;
    logic        addr_ack = 1'b0;
    logic        data_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    addr_arb u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_req    (ext_req),
        .ext_gnt    (ext_gnt),
        .int_req    (int_req),
        .int_lvl    (int_lvl),
        .int_gnt    (int_gnt),
        .prio_cfg   (prio_cfg),
        .pipe_one   (pipe_one),
        .xfer_start (xfer_start),
        .addr_ack   (addr_ack),
        .data_done  (data_done)
    );

    typedef struct packed {
        logic [2:0]  ext;
        logic [3:0]  intr;
        logic [11:0] lvl;
        logic [20:0] cfg;
        logic [6:0]  exp;
    } vec_t;

    // cfg = {p6,p5,p4,p3,p2,p1,p0}; lvl = {l3,l2,l1,l0}; exp = {int3..int0, ext2..ext0}
    localparam vec_t VECS [8] = '{
        '{3'b001, 4'b0000, 12'd0, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 7'b0000001},
        '{3'b111, 4'b0000, 12'd0, {3'd0,3'd0,3'd0,3'd0,3'd3,3'd5,3'd1}, 7'b0000010},
        '{3'b101, 4'b0000, 12'd0, {3'd2,3'd2,3'd2,3'd2,3'd2,3'd2,3'd2}, 7'b0000001},
        '{3'b000, 4'b1100, 12'd0, {3'd4,3'd4,3'd4,3'd4,3'd4,3'd4,3'd4}, 7'b0100000},
        '{3'b100, 4'b0001, {3'd0,3'd0,3'd0,3'd7}, {3'd0,3'd0,3'd0,3'd1,3'd6,3'd0,3'd0}, 7'b0001000},
        '{3'b010, 4'b0010, {3'd0,3'd0,3'd3,3'd0}, {3'd0,3'd0,3'd2,3'd0,3'd0,3'd5,3'd0}, 7'b0000010},
        '{3'b000, 4'b1111, {3'd1,3'd6,3'd6,3'd2}, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 7'b0010000},
        '{3'b111, 4'b1111, {3'd7,3'd7,3'd7,3'd7}, {3'd7,3'd7,3'd7,3'd7,3'd7,3'd7,3'd7}, 7'b0000001}
    };

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [6:0] exp);
        logic [6:0] act;
        act = {int_gnt, ext_gnt};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s grant act=%b exp=%b", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick; tick;
        check("R10 reset grants low", 7'b0);
        rst_n = 1'b1;
        tick;
        check("R10 idle after reset", 7'b0);

        // Table of selection vectors, each followed by a full tenure.
        for (int v = 0; v < 8; v++) begin
            ext_req  = VECS[v].ext;
            int_req  = VECS[v].intr;
            int_lvl  = VECS[v].lvl;
            prio_cfg = VECS[v].cfg;
            tick;
            check($sformatf("R2 R3 R4 R6 vector %0d winner", v), VECS[v].exp);
            xfer_start = 1'b1; ext_req = '0; int_req = '0;
            tick;
            check($sformatf("R7 vector %0d drop after start", v), 7'b0);
            xfer_start = 1'b0; addr_ack = 1'b1;
            tick;
            addr_ack = 1'b0; data_done = 1'b1;
            tick;
            data_done = 1'b0;
        end

        // R7: grant held and not moved by a new request.
        prio_cfg = '0; int_lvl = '0; pipe_one = 1'b0;
        ext_req = 3'b001;
        tick;
        check("R6 idle request granted", 7'b0000001);
        ext_req = 3'b010;
        tick; tick; tick;
        check("R7 grant held without start", 7'b0000001);
        xfer_start = 1'b1;
        tick;
        xfer_start = 1'b0;
        check("R7 grant dropped after start", 7'b0);
        tick;
        check("R11 no grant during address tenure", 7'b0);
        addr_ack = 1'b1;
        tick;
        addr_ack = 1'b0;
        check("R8 depth zero withholds grant", 7'b0);
        tick;
        check("R8 still withheld", 7'b0);
        data_done = 1'b1;
        tick;
        data_done = 1'b0;
        check("R8 grant on data completion", 7'b0000010);

        // One level of pipelining.
        pipe_one = 1'b1;
        ext_req = 3'b100;
        xfer_start = 1'b1;
        tick;
        xfer_start = 1'b0; addr_ack = 1'b1;
        tick;
        addr_ack = 1'b0;
        check("R5 R9 grant one clock after ack with one outstanding", 7'b0000100);
        ext_req = 3'b001;
        xfer_start = 1'b1;
        tick;
        xfer_start = 1'b0; addr_ack = 1'b1;
        tick;
        addr_ack = 1'b0;
        check("R9 withheld at two outstanding", 7'b0);
        data_done = 1'b1;
        tick;
        data_done = 1'b0;
        check("R9 grant after count falls to one", 7'b0000001);
        ext_req = '0;
        xfer_start = 1'b1;
        tick;
        xfer_start = 1'b0; addr_ack = 1'b1;
        tick;
        addr_ack = 1'b0; data_done = 1'b1;
        tick; tick;
        data_done = 1'b0;

        // R10: reset mid-run clears grant and counter.
        pipe_one = 1'b0;
        ext_req = 3'b001;
        tick;
        xfer_start = 1'b1; ext_req = '0;
        tick;
        xfer_start = 1'b0; addr_ack = 1'b1;
        tick;
        addr_ack = 1'b0;
        ext_req = 3'b010;
        tick;
        check("R8 pending request held off by count", 7'b0);
        ext_req = '0;
        ext_req = 3'b100;
        tick;
        ext_req = '0;
        rst_n = 1'b0;
        tick; tick;
        check("R10 grants cleared by reset", 7'b0);
        rst_n = 1'b1;
        ext_req = 3'b001;
        tick;
        check("R10 counter cleared, grant next clock", 7'b0000001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule